// File: doc/BRIEF.md
# Timing-Error Recovery Stage with Partial Time Redundancy

This block is one pipeline stage that checks itself for late-arriving results. Its combinational work is split into two sections. The first section's output is held in a register stage. A second copy of the second section is fed from that held value, so its input paths are short. The copy's answer is sampled one clock-enable later and compared with the main path's answer, which was captured in a single cycle through both sections. A result leaves the stage only after this compare agrees.

When the two answers differ, the stage treats the difference as a timing fault and recovers in a fixed order. First it raises a retry pulse and drops to a slower clock-enable rate. On the next enabled cycle it pulses a flush for downstream logic. On the enabled cycle after that it reissues the failed operation from a held copy of its input. After a set number of clean compares in slow mode it returns to full rate.

A fault-injection input flips the least significant bit of the main-path capture. A bench can use it to force the full recovery sequence.

Top module: `trs_stage`

## Requirements
- R1: After reset, `out_valid`, `retry`, `flush` and `slow_mode` are 0, `fault_count` is 0 and `in_ready` is 1.
- R2: For accepted input d (16-bit default), `out_data` is g(f(d)). Here f(x) = x + (x rotated by half its width), and g(m) = (3·m) XOR KEY (default 0xA5C3), both truncated to the data width. At full rate, `out_valid` pulses for one clock, two clocks after the accepting clock.
- R3: At full rate the stage accepts one input per clock, and results come out in acceptance order, one per clock.
- R4: When `fault_inj` is high at the accepting clock, the main capture has bit 0 inverted. That operation produces no `out_valid`. Instead, `retry` pulses two clocks after acceptance and `fault_count` rises by one.
- R5: Recovery order is fixed. `slow_mode` rises together with the `retry` pulse. `flush` pulses for one clock on the next enabled cycle, and the reissue capture takes place on the enabled cycle after that. `out_valid`, `retry` and `flush` are never high together.
- R6: In slow mode the clock enable is active one clock in SLOW_DIV (default 2). `in_ready` is never high on two consecutive clocks, and latency from accept to `out_valid` is 1+SLOW_DIV clocks.
- R7: The reissued operation yields the correct result from the held input, delivered exactly once, six clocks after the `retry` pulse at default settings.
- R8: A fault during the reissue raises another `retry`, increments `fault_count` again, keeps `slow_mode` high and reissues again until the compare is clean.
- R9: After RECOVER_OPS consecutive clean compares in slow mode, counting the reissue, `slow_mode` falls on the clock that commits the last of them. Full-rate latency then resumes.
- R10: `fault_count` never decreases and saturates at all ones.
- R11: `in_ready` stays low from the clock after the faulted accept until the reissue has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand offered |
| in_data | input | DATA_W | Input operand |
| fault_inj | input | 1 | Invert bit 0 of the main capture for an operation accepted now |
| in_ready | output | 1 | Stage takes the operand at this clock |
| out_valid | output | 1 | One-clock pulse: checked result available |
| out_data | output | DATA_W | Checked result |
| retry | output | 1 | One-clock pulse: compare mismatch detected |
| flush | output | 1 | One-clock pulse: discard downstream in-flight work |
| slow_mode | output | 1 | Clock enable runs at reduced rate |
| fault_count | output | FCNT_W | Saturating count of detected faults |

## Verification
A wrong controller state is visible at the ports within a few clocks. A compare that passes when it should fail puts a corrupted value on `out_data` two clocks after acceptance. A compare that fails when it should pass produces a `retry` where an `out_valid` was expected. A faulty divider or recovery counter changes the accept-to-result latency and the spacing of `in_ready`. The bench measures that spacing in clocks. A lost or misordered recovery step shifts the `flush` pulse away from two clocks after `retry`, or shifts the reissued result away from six clocks after it, or delivers that result twice or not at all.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // recovery controller phases
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_FLUSH   = 2'd1,
        ST_REISSUE = 2'd2
    } trs_state_e;

    // number of copies of the second section (main + shadow)
    localparam int unsigned SEC2_COPIES = 2;
    localparam int unsigned SEC2_MAIN   = 0;
    localparam int unsigned SEC2_SHADOW = 1;

endpackage

// File: rtl/trs_sec1.sv
module trs_sec1 #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] mid
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] rot;

    always_comb begin
        rot = {din[H-1:0], din[W-1:H]};
        mid = din + rot;
    end
endmodule

// File: rtl/trs_sec2.sv
module trs_sec2 #(
    parameter int unsigned W   = 16,
    parameter logic [W-1:0] KEY = 16'hA5C3
) (
    input  logic [W-1:0] mid,
    output logic [W-1:0] res
);
    logic [W-1:0] tri_v;

    always_comb begin
        tri_v = (mid << 1) + mid;
        res   = tri_v ^ KEY;
    end
endmodule

// File: rtl/trs_ce_div.sv
module trs_ce_div #(
    parameter int unsigned SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_q,
    output logic ce
);
    localparam int unsigned CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        ce = !slow_q || (cnt_q == LAST);
        if (!slow_q) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/trs_stage.sv
module trs_stage
    import trs_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter logic [DATA_W-1:0] SEC2_KEY = 16'hA5C3,
    parameter int unsigned SLOW_DIV    = 2,
    parameter int unsigned RECOVER_OPS = 4,
    parameter int unsigned FCNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fault_inj,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              retry,
    output logic              flush,
    output logic              slow_mode,
    output logic [FCNT_W-1:0] fault_count
);
    localparam int unsigned OKW = $clog2(RECOVER_OPS + 1);
    localparam logic [OKW-1:0] OK_LAST = OKW'(RECOVER_OPS - 1);
    localparam logic [DATA_W-1:0] INJ_MASK = DATA_W'(1);

    typedef struct packed {
        trs_state_e        state;
        logic              a_vld;
        logic [DATA_W-1:0] a_in;
        logic [DATA_W-1:0] a_x;
        logic [DATA_W-1:0] a_main;
        logic [DATA_W-1:0] rep;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
        logic              retry;
        logic              flush;
        logic              slow;
        logic [OKW-1:0]    ok_cnt;
        logic [FCNT_W-1:0] fcnt;
    } regs_t;

    regs_t q, d;

    logic              ce;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] mid;
    logic [DATA_W-1:0] main_cap;
    logic              mismatch;
    logic              take_new;
    logic [DATA_W-1:0] s2_in  [SEC2_COPIES];
    logic [DATA_W-1:0] s2_out [SEC2_COPIES];

    // clock-enable divider: full rate or one enable in SLOW_DIV clocks
    trs_ce_div #(
        .SLOW_DIV (SLOW_DIV)
    ) ce_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .slow_q (q.slow),
        .ce     (ce)
    );

    // first section feeds the main copy of the second section
    assign src = (q.state == ST_REISSUE) ? q.rep : in_data;

    trs_sec1 #(
        .W (DATA_W)
    ) sec1_i (
        .din (src),
        .mid (mid)
    );

    // main and shadow copies of the second section
    assign s2_in[SEC2_MAIN]   = mid;
    assign s2_in[SEC2_SHADOW] = q.a_x;

    for (genvar g = 0; g < SEC2_COPIES; g++) begin : g_sec2
        trs_sec2 #(
            .W   (DATA_W),
            .KEY (SEC2_KEY)
        ) sec2_i (
            .mid (s2_in[g]),
            .res (s2_out[g])
        );
    end

    assign main_cap = fault_inj ? (s2_out[SEC2_MAIN] ^ INJ_MASK) : s2_out[SEC2_MAIN];
    assign mismatch = q.a_vld && (q.a_main != s2_out[SEC2_SHADOW]);
    assign in_ready = ce && (q.state == ST_RUN) && !mismatch;
    assign take_new = in_ready && in_valid;

    always_comb begin
        d         = q;
        d.out_vld = 1'b0;
        d.retry   = 1'b0;
        d.flush   = 1'b0;

        if (ce) begin
            d.a_vld = 1'b0;

            // late compare of the operation captured on the previous enable
            if (q.a_vld) begin
                if (mismatch) begin
                    d.retry  = 1'b1;
                    d.slow   = 1'b1;
                    d.ok_cnt = '0;
                    d.rep    = q.a_in;
                    d.state  = ST_FLUSH;
                    if (q.fcnt != '1) begin
                        d.fcnt = q.fcnt + 1'b1;
                    end
                end else begin
                    d.out_vld  = 1'b1;
                    d.out_data = q.a_main;
                    if (q.slow) begin
                        if (q.ok_cnt == OK_LAST) begin
                            d.slow   = 1'b0;
                            d.ok_cnt = '0;
                        end else begin
                            d.ok_cnt = q.ok_cnt + 1'b1;
                        end
                    end
                end
            end

            unique case (q.state)
                ST_FLUSH: begin
                    d.flush = 1'b1;
                    d.a_vld = 1'b0;
                    d.state = ST_REISSUE;
                end
                ST_REISSUE: begin
                    d.a_vld  = 1'b1;
                    d.a_in   = src;
                    d.a_x    = mid;
                    d.a_main = main_cap;
                    d.state  = ST_RUN;
                end
                default: begin
                    if (take_new) begin
                        d.a_vld  = 1'b1;
                        d.a_in   = src;
                        d.a_x    = mid;
                        d.a_main = main_cap;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_RUN;
            q.a_vld    <= 1'b0;
            q.a_in     <= '0;
            q.a_x      <= '0;
            q.a_main   <= '0;
            q.rep      <= '0;
            q.out_vld  <= 1'b0;
            q.out_data <= '0;
            q.retry    <= 1'b0;
            q.flush    <= 1'b0;
            q.slow     <= 1'b0;
            q.ok_cnt   <= '0;
            q.fcnt     <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.out_vld;
    assign out_data    = q.out_data;
    assign retry       = q.retry;
    assign flush       = q.flush;
    assign slow_mode   = q.slow;
    assign fault_count = q.fcnt;

endmodule

// File: rtl/trs_stage_chk.sv
module trs_stage_chk #(
    parameter int unsigned FCNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              retry,
    input logic              flush,
    input logic              slow_mode,
    input logic [FCNT_W-1:0] fault_count
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, retry, flush})); // R5

    AST_RETRY_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> slow_mode); // R5

    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush); // R5

    AST_RETRY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !in_ready); // R11

    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_mode && in_ready) |=> (!in_ready || !slow_mode)); // R6

    AST_FCNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        fault_count >= $past(fault_count)); // R10

    AST_RETRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry) |-> ((fault_count == FCNT_W'($past(fault_count) + 1'b1)) || (&fault_count))); // R4

endmodule

bind trs_stage trs_stage_chk #(
    .FCNT_W (FCNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .retry       (retry),
    .flush       (flush),
    .slow_mode   (slow_mode),
    .fault_count (fault_count)
);

// File: tb/trs_stage_tb_top.sv
`timescale 1ns/1ps
module trs_stage_tb_top;
    localparam int unsigned W       = 16;
    localparam logic [15:0] KEY     = 16'hA5C3;
    localparam int unsigned SDIV    = 2;
    localparam int unsigned ROPS    = 4;
    localparam int unsigned FW      = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          fault_inj = 1'b0;
    logic          in_ready, out_valid, retry, flush, slow_mode;
    logic [W-1:0]  out_data;
    logic [FW-1:0] fault_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_retry = 0, last_retry = -1;
    int n_flush = 0, last_flush = -1;
    int got_d[$];
    int got_c[$];
    bit done = 1'b0;

    trs_stage #(
        .DATA_W      (W),
        .SEC2_KEY    (KEY),
        .SLOW_DIV    (SDIV),
        .RECOVER_OPS (ROPS),
        .FCNT_W      (FW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .fault_inj   (fault_inj),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .retry       (retry),
        .flush       (flush),
        .slow_mode   (slow_mode),
        .fault_count (fault_count)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                got_d.push_back(int'(out_data));
                got_c.push_back(cyc);
            end
            if (retry) begin
                n_retry++;
                last_retry = cyc;
            end
            if (flush) begin
                n_flush++;
                last_flush = cyc;
            end
        end
    end

    function automatic logic [15:0] ref_f(input logic [15:0] x);
        logic [15:0] s1, t;
        s1 = x + {x[7:0], x[15:8]};
        t  = (s1 << 1) + s1;
        return t ^ KEY;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        got_d.delete();
        got_c.delete();
    endtask

    // offers one operand; returns the cycle stamp of the accepting clock
    task automatic send(input logic [W-1:0] x, input bit inj, output int acc);
        int guard = 0;
        in_valid  = 1'b1;
        in_data   = x;
        fault_inj = inj;
        while (!in_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        acc = cyc;
        @(negedge clk);
        in_valid  = 1'b0;
        fault_inj = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(retry == 1'b0 && flush == 1'b0, "R1", "retry|flush", {retry, flush}, 0);
        check(slow_mode == 1'b0, "R1", "slow_mode", slow_mode, 0);
        check(fault_count == '0, "R1", "fault_count", fault_count, 0);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    endtask

    task automatic t_single();
        logic [15:0] vals [3] = '{16'h1234, 16'h0000, 16'hFFFF};
        int acc;
        foreach (vals[i]) begin
            clear_log();
            send(vals[i], 1'b0, acc);
            repeat (3) @(negedge clk);
            check(got_d.size() == 1, "R2", "result count", got_d.size(), 1);
            if (got_d.size() == 1) begin
                check(got_d[0] == int'(ref_f(vals[i])), "R2", "result", got_d[0], ref_f(vals[i]));
                check(got_c[0] - acc == 2, "R2", "latency", got_c[0] - acc, 2);
            end
        end
    endtask

    task automatic t_stream();
        logic [15:0] v [8];
        int accs [8];
        for (int i = 0; i < 8; i++) v[i] = 16'(i * 16'h1357) ^ 16'hC0DE;
        clear_log();
        for (int i = 0; i < 8; i++) send(v[i], 1'b0, accs[i]);
        repeat (4) @(negedge clk);
        check(got_d.size() == 8, "R3", "stream count", got_d.size(), 8);
        for (int i = 0; i < 8; i++) begin
            check(accs[i] - accs[0] == i, "R3", "accept spacing", accs[i] - accs[0], i);
            if (i < got_d.size()) begin
                check(got_d[i] == int'(ref_f(v[i])), "R3", "stream data", got_d[i], ref_f(v[i]));
                check(got_c[i] - got_c[0] == i, "R3", "output spacing", got_c[i] - got_c[0], i);
            end
        end
    endtask

    task automatic t_fault_and_recover();
        int acc, a2, r0, f0, ready_hits, ones, pairs;
        bit prev;
        logic [15:0] x = 16'hBEEF;
        clear_log();
        r0 = n_retry;
        f0 = int'(fault_count);
        send(x, 1'b1, acc);
        ready_hits = 0;
        for (int k = 1; k <= 6; k++) begin
            if (in_ready) ready_hits++;
            if (k == 2) begin
                check(slow_mode == 1'b1, "R5", "slow with retry", slow_mode, 1);
                check(int'(fault_count) == f0 + 1, "R4", "fault_count", fault_count, f0 + 1);
            end
            @(negedge clk);
        end
        check(ready_hits == 0, "R11", "in_ready during recovery", ready_hits, 0);
        repeat (3) @(negedge clk);
        check(n_retry - r0 == 1, "R4", "retry pulses", n_retry - r0, 1);
        check(last_retry == acc + 2, "R4", "retry timing", last_retry - acc, 2);
        check(last_flush == last_retry + SDIV, "R5", "flush after retry", last_flush - last_retry, SDIV);
        check(got_d.size() == 1, "R7", "reissue count", got_d.size(), 1);
        if (got_d.size() == 1) begin
            check(got_d[0] == int'(ref_f(x)), "R7", "reissue data", got_d[0], ref_f(x));
            check(got_c[0] - last_retry == 6, "R7", "reissue timing", got_c[0] - last_retry, 6);
        end
        // idle slow mode: enable every other clock
        ones = 0; pairs = 0; prev = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (in_ready) ones++;
            if (in_ready && prev) pairs++;
            prev = in_ready;
            @(negedge clk);
        end
        check(ones == 3 && pairs == 0, "R6", "slow ready pattern", ones * 16 + pairs, 3 * 16);
        // three more clean ops finish the recovery window
        for (int j = 0; j < ROPS - 1; j++) begin
            clear_log();
            send(16'(16'h2222 * (j + 1)), 1'b0, a2);
            repeat (3) @(negedge clk);
            check(got_d.size() == 1 && got_c[0] - a2 == 1 + SDIV, "R6", "slow latency",
                  (got_d.size() == 1) ? got_c[0] - a2 : -1, 1 + SDIV);
            if (j < ROPS - 2) check(slow_mode == 1'b1, "R9", "still slow", slow_mode, 1);
            else              check(slow_mode == 1'b0, "R9", "back to full rate", slow_mode, 0);
        end
        clear_log();
        send(16'h7A7A, 1'b0, a2);
        repeat (3) @(negedge clk);
        check(got_d.size() == 1 && got_c[0] - a2 == 2, "R9", "full latency again",
              (got_d.size() == 1) ? got_c[0] - a2 : -1, 2);
    endtask

    task automatic t_double_fault();
        int acc, r0, f0, guard;
        logic [15:0] x = 16'h4C1D;
        clear_log();
        r0 = n_retry;
        f0 = int'(fault_count);
        send(x, 1'b1, acc);
        fault_inj = 1'b1;
        guard = 0;
        while (n_retry - r0 < 2 && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        fault_inj = 1'b0;
        repeat (10) @(negedge clk);
        check(n_retry - r0 == 2, "R8", "retry pulses", n_retry - r0, 2);
        check(int'(fault_count) == f0 + 2, "R8", "fault_count", fault_count, f0 + 2);
        check(slow_mode == 1'b1, "R8", "slow kept", slow_mode, 1);
        check(got_d.size() == 1, "R8", "result count", got_d.size(), 1);
        if (got_d.size() == 1)
            check(got_d[0] == int'(ref_f(x)), "R8", "result", got_d[0], ref_f(x));
    endtask

    task automatic t_saturate();
        int acc, r0, guard;
        guard = 0;
        while (fault_count != '1 && guard < 12) begin
            send(16'(16'h0101 * guard), 1'b1, acc);
            repeat (20) @(negedge clk);
            guard++;
        end
        check(fault_count == '1, "R10", "count reaches max", fault_count, 7);
        r0 = n_retry;
        clear_log();
        send(16'h9999, 1'b1, acc);
        repeat (20) @(negedge clk);
        check(n_retry - r0 == 1, "R10", "retry at max", n_retry - r0, 1);
        check(fault_count == '1, "R10", "count saturated", fault_count, 7);
        check(got_d.size() == 1 && got_d[0] == int'(ref_f(16'h9999)), "R10", "result at max",
              (got_d.size() > 0) ? got_d[0] : -1, ref_f(16'h9999));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_stream();
        t_fault_and_recover();
        t_double_fault();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end
endmodule